// File: doc/BRIEF.md
# Channel Load Measurement Counter

This block estimates how busy a radio channel is. Once armed, it samples a clear-channel-assessment busy line once per 4 us strobe, over a window whose length software sets in 4 us units. It counts the strobes that found the channel busy. When the window closes, the count stays on a 16-bit result output and a sticky ready flag rises.

Software programs the window length and sets the enable bit. It then drives the trigger bit low and then high. The rising edge of the trigger starts a new window. Software may read the result at any time after ready is set. The 4 us strobe comes from a divider of the system clock. The divider length is a parameter, so the block can run from any clock that is a whole multiple of 250 kHz.

Top module: `chan_load_meter`

## Requirements
- R1: After reset, `load_count` is 0 and `load_ready` is 0.
- R2: A rising edge on `meas_trigger` while `meas_enable` is 1 starts a new window. It clears `load_count` and `load_ready` on the clock edge that detects it. Holding `meas_trigger` high starts no further window.
- R3: Each window sample is taken every TICK_CYCLES clocks, and the first one TICK_CYCLES clocks after the starting edge. `load_ready` rises exactly TICK_CYCLES × period clocks after the starting edge.
- R4: `load_count` equals the number of samples in the window at which `cca_busy` was 1.
- R5: `load_ready` stays 1, and `load_count` holds its value, until the next accepted trigger edge.
- R6: A window started with a period of 0 sets `load_ready` on the next clock, with `load_count` 0.
- R7: The period is captured at the trigger edge. Changing `win_period` during a window has no effect on that window.
- R8: A trigger edge while `meas_enable` is 0 is ignored. Dropping `meas_enable` during a window abandons it: `load_ready` stays 0 and `load_count` keeps the partial count.
- R9: A trigger edge during a running window restarts the measurement from zero with the newly captured period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_period | input | 16 | Window length in 4 us samples |
| meas_enable | input | 1 | Enables the measurement engine |
| meas_trigger | input | 1 | A rising edge arms a new window |
| cca_busy | input | 1 | Channel-busy indication being sampled |
| load_count | output | 16 | Busy samples counted in the current or last window |
| load_ready | output | 1 | Sticky flag: the window has completed |

## Verification
The hardest cases to reach are events that land inside a running window: a second trigger edge, a period rewrite, or enable dropping midway. Each must take effect at a precise sample boundary. The bench steps the busy line at the negative clock edge right after each strobe, so it always knows which sample a value falls into. It then injects the disturbing event after a known number of strobes and checks the partial count and the final count. Exact latency is proven by checking that ready is still low one clock before the expected completion edge and high one clock later.

// File: rtl/chan_load_meter.sv
module chan_load_meter #(
  parameter int TICK_CYCLES = 160,
  parameter int PERIOD_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] win_period,
  input  logic                meas_enable,
  input  logic                meas_trigger,
  input  logic                cca_busy,
  output logic [PERIOD_W-1:0] load_count,
  output logic                load_ready
);
  localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYCLES - 1);

  logic                trig_q;
  logic                running;
  logic [DIV_W-1:0]    div_cnt;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] smp_cnt;
  logic [PERIOD_W-1:0] busy_cnt;
  logic                ready_q;

  wire start = meas_enable & meas_trigger & ~trig_q;
  wire tick  = running & (div_cnt == DIV_LAST);
  wire last  = tick & (smp_cnt == period_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      running  <= 1'b0;
      div_cnt  <= '0;
      period_q <= '0;
      smp_cnt  <= '0;
      busy_cnt <= '0;
      ready_q  <= 1'b0;
    end else begin
      trig_q <= meas_trigger;
      if (start) begin
        period_q <= win_period;
        smp_cnt  <= '0;
        busy_cnt <= '0;
        div_cnt  <= '0;
        ready_q  <= (win_period == '0);
        running  <= (win_period != '0);
      end else if (!meas_enable) begin
        running <= 1'b0;
      end else if (running) begin
        if (tick) begin
          div_cnt <= '0;
          smp_cnt <= smp_cnt + 1'b1;
          if (cca_busy) busy_cnt <= busy_cnt + 1'b1;
          if (last) begin
            running <= 1'b0;
            ready_q <= 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign load_count = busy_cnt;
  assign load_ready = ready_q;

  assert_trig_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && win_period != '0) |=> (!load_ready && load_count == '0));

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_count <= smp_cnt);

  assert_count_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(tick && cca_busy)) |=> $stable(load_count));

  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ready && !start) |=> load_ready);

  assert_zero_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && win_period == '0) |=> (load_ready && load_count == '0));

  assert_disabled_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_enable |=> !$rose(load_ready));
endmodule

// File: tb/chan_load_meter_tb.sv
module chan_load_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NV = 6;
  localparam int VP [NV] = '{5, 6, 7, 4, 1, 10};
  localparam int VM [NV] = '{1, 2, 3, 0, 1, 4};
  localparam int VE [NV] = '{5, 3, 3, 0, 1, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] win_period = '0;
  logic meas_enable = 1'b0;
  logic meas_trigger = 1'b0;
  logic cca_busy = 1'b0;
  logic [15:0] load_count;
  logic load_ready;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_load_meter #(.TICK_CYCLES(DIV), .PERIOD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_period(win_period), .meas_enable(meas_enable),
    .meas_trigger(meas_trigger), .cca_busy(cca_busy),
    .load_count(load_count), .load_ready(load_ready));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) meas_trigger = 1'b0;
    @(negedge clk) meas_trigger = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++; tests++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    waitn(3);
    check("R1 count", load_count, 0);
    check("R1 ready", load_ready, 0);
    rst_n = 1'b1;
    meas_enable = 1'b1;

    for (int v = 0; v < NV; v++) begin
      win_period = 16'(VP[v]);
      pulse_trig();
      check("R2 cleared", load_count, 0);
      for (int k = 0; k < VP[v]; k++) begin
        cca_busy = (VM[v] != 0) && (k % VM[v] == 0);
        waitn(DIV - 1);
        if (k == VP[v] - 1) check("R3 ready not early", load_ready, 0);
        waitn(1);
      end
      check("R3 ready on time", load_ready, 1);
      check("R4 busy count", load_count, VE[v]);
    end

    waitn(20);
    check("R5 ready sticky", load_ready, 1);
    check("R5 count held", load_count, 3);

    meas_enable = 1'b0;
    win_period = 16'd2;
    pulse_trig();
    waitn(3 * DIV);
    check("R8 disabled trig ready", load_ready, 1);
    check("R8 disabled trig count", load_count, 3);
    meas_enable = 1'b1;

    win_period = 16'd0;
    pulse_trig();
    check("R6 zero ready", load_ready, 1);
    check("R6 zero count", load_count, 0);

    cca_busy = 1'b1;
    win_period = 16'd3;
    pulse_trig();
    win_period = 16'd100;
    waitn(3 * DIV - 1);
    check("R7 not early", load_ready, 0);
    waitn(1);
    check("R7 ready", load_ready, 1);
    check("R7 count", load_count, 3);

    win_period = 16'd8;
    pulse_trig();
    waitn(3 * DIV);
    check("R9 partial", load_count, 3);
    check("R9 partial ready", load_ready, 0);
    win_period = 16'd2;
    @(negedge clk) meas_trigger = 1'b0;
    @(negedge clk) meas_trigger = 1'b1;
    @(negedge clk);
    check("R9 restart clears", load_count, 0);
    waitn(2 * DIV - 1);
    check("R9 not early", load_ready, 0);
    waitn(1);
    check("R9 ready", load_ready, 1);
    check("R9 count", load_count, 2);

    win_period = 16'd10;
    pulse_trig();
    waitn(2 * DIV);
    meas_enable = 1'b0;
    waitn(12 * DIV);
    check("R8 abandoned ready", load_ready, 0);
    check("R8 partial kept", load_count, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule